// File: doc/BRIEF.md
# DMA Channel Register and Progress Engine

This block holds the programming and progress state of a single bus-master DMA channel that works next to a SCSI protocol core. Software programs a start count, start address and start descriptor address, then writes a command word. The start command copies the programmed values into working copies and raises the enable line toward the core. An idle command drops that line. An abort command sends a one-cycle cancel pulse to the core. A flush command is accepted and does nothing.

While a transfer runs, the memory-side engine offers each data chunk on a valid/ready stream. The chunk carries a direction and a requested length. The block answers in the same cycle with the granted length, which is the requested length capped at the remaining count. When the chunk is taken, the block lowers the working count and advances the working address. A chunk whose direction disagrees with the programmed direction is refused: its grant is zero and no state moves. `chunk_ready` is low in any cycle that carries a register write, so register writes win over chunk traffic. A chunk that is offered may stay valid across such cycles, and the bench holds nothing else against it.

The done, abort and error flags follow one of two clearing rules, picked by an external mode input. In one mode they are cleared by writing ones. In the other, status writes are ignored and reading the status clears them. The SCSI interrupt flag is not stored: it mirrors the core's interrupt line live. A completion event from the core empties the count and sets done.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the register at index 0 (command) reads 0. Index 1 (start count), index 2 (start address), index 3 (working count), index 5 (status) and index 6 (start descriptor) also read 0. Index 4 (working address) reads 0xFFFFFFFF, index 7 (working descriptor) reads 0xFFFFFFFD, and `dma_en` and `core_cancel` are low.
- R2: Writes to indices 0, 1, 2 and 6 store all 32 bits, which read back unchanged. Writes to indices 3, 4 and 7 change nothing.
- R3: A command write whose bits [1:0] equal 3 (start) has four effects. It copies index 1 into index 3, index 2 into index 4, and index 6 into index 7. It clears status bits [5:0]. It sets `dma_en` from the next cycle.
- R4: A command write with bits [1:0] equal 0 (idle) clears `dma_en`. With bits [1:0] equal 2 (abort), `core_cancel` is high for exactly the one cycle after the write. With bits [1:0] equal 1 (flush), neither output changes.
- R5: `chunk_ready` is the inverse of `reg_wr`. For a chunk whose direction matches, `chunk_grant` equals the smaller of `chunk_len` and the working count. A taken chunk (`chunk_valid` and `chunk_ready` both high) lowers the working count by the grant and raises the working address by the grant.
- R6: Command bit 7 set means device-to-memory, which is matched by `chunk_to_mem` = 1. A chunk whose direction does not match gets a grant of 0 and leaves both working count and working address unchanged.
- R7: A taken chunk that brings the working count to zero sets status bit 3 (done).
- R8: With `stat_w1c_mode` high, a write to status clears each of bit 1 (error), bit 2 (abort) and bit 3 (done) whose write-data bit is 1, and a status read clears nothing.
- R9: With `stat_w1c_mode` low, writes to status have no effect. A status read returns the current value, and status bits [3:1] are zero afterwards.
- R10: Status bit 4 reads as the live value of `core_irq` and is never held.
- R11: A pulse on `core_cmd_done` forces the working count to 0 and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status side effects) |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| stat_w1c_mode | input | 1 | 1: write-one-to-clear, 0: clear-on-read |
| core_irq | input | 1 | Interrupt line of the SCSI core |
| core_cmd_done | input | 1 | Command-complete pulse from the core |
| dma_en | output | 1 | DMA enable toward the core |
| core_cancel | output | 1 | One-cycle cancel request toward the core |
| chunk_valid | input | 1 | Chunk offer valid |
| chunk_ready | output | 1 | Chunk accepted this cycle when high |
| chunk_to_mem | input | 1 | Chunk direction, 1 = device to memory |
| chunk_len | input | 32 | Requested chunk length in bytes |
| chunk_grant | output | 32 | Granted length, combinational |

## Verification
A wrong working count or address shows up in the grant of the next chunk offered. It also shows on the first read of index 3 or 4, no later than the next operation. A status flag that is set or cleared wrongly shows on the next status read. Because that read may itself clear the flag, the bench reads again right after to check the clearing rule of the current mode. Errors in the enable line and the cancel pulse are seen one cycle after the command write that should cause them.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD  = 3'd0,
    IX_SCNT = 3'd1,
    IX_SADR = 3'd2,
    IX_WCNT = 3'd3,
    IX_WADR = 3'd4,
    IX_STAT = 3'd5,
    IX_SDSC = 3'd6,
    IX_WDSC = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } cmd_op_e;

  localparam int unsigned CMD_DIR_BIT = 7;

  localparam int unsigned ST_W     = 6;
  localparam int unsigned ST_ERR   = 1;
  localparam int unsigned ST_ABT   = 2;
  localparam int unsigned ST_DONE  = 3;
  localparam int unsigned ST_IRQ   = 4;

endpackage

// File: rtl/dmac_cmd.sv
module dmac_cmd
  import dmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic              start_p,
  output logic              dma_en,
  output logic              cancel
);

  cmd_op_e op;
  assign op      = cmd_op_e'(wdata[1:0]);
  assign start_p = wr_en && (op == OP_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      dma_en <= 1'b0;
      cancel <= 1'b0;
    end else begin
      cancel <= wr_en && (op == OP_ABORT);
      if (wr_en) begin
        cmd_q <= wdata;
        unique case (op)
          OP_IDLE:  dma_en <= 1'b0;
          OP_START: dma_en <= 1'b1;
          default:  dma_en <= dma_en;
        endcase
      end
    end
  end

  AST_EN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> dma_en); // R3
  AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !(wr_en && op == OP_ABORT)) |=> !cancel); // R4
  AST_FLUSH_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_FLUSH) |=> $stable(dma_en)); // R4

endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_WADR = '1,
  parameter logic [DATA_W-1:0] RST_WDSC = {{(DATA_W-2){1'b1}}, 2'b01}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_scnt,
  input  logic              wr_sadr,
  input  logic              wr_sdsc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start_p,
  input  logic              cmd_dir,
  input  logic              done_evt,
  input  logic              chk_valid,
  input  logic              chk_ready,
  input  logic              chk_to_mem,
  input  logic [DATA_W-1:0] chk_len,
  output logic [DATA_W-1:0] scnt_q,
  output logic [DATA_W-1:0] sadr_q,
  output logic [DATA_W-1:0] sdsc_q,
  output logic [DATA_W-1:0] wcnt_q,
  output logic [DATA_W-1:0] wadr_q,
  output logic [DATA_W-1:0] wdsc_q,
  output logic [DATA_W-1:0] grant,
  output logic              set_done
);

  logic              dir_ok;
  logic              fire;
  logic [DATA_W-1:0] clamp;

  assign dir_ok   = (chk_to_mem == cmd_dir);
  assign clamp    = (chk_len < wcnt_q) ? chk_len : wcnt_q;
  assign grant    = dir_ok ? clamp : '0;
  assign fire     = chk_valid && chk_ready && dir_ok;
  assign set_done = done_evt || (fire && (clamp == wcnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
    end else begin
      if (wr_scnt) scnt_q <= wdata;
      if (wr_sadr) sadr_q <= wdata;
      if (wr_sdsc) sdsc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      wadr_q <= RST_WADR;
      wdsc_q <= RST_WDSC;
    end else begin
      if (done_evt)     wcnt_q <= '0;
      else if (start_p) wcnt_q <= scnt_q;
      else if (fire)    wcnt_q <= wcnt_q - clamp;

      if (start_p)   wadr_q <= sadr_q;
      else if (fire) wadr_q <= wadr_q + clamp;

      if (start_p) wdsc_q <= sdsc_q;
    end
  end

  AST_GRANT_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    grant <= wcnt_q); // R5
  AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_ready && dir_ok && !start_p) |=> wadr_q == $past(wadr_q) + $past(grant)); // R5
  AST_MISMATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !dir_ok && !start_p && !done_evt) |=> ($stable(wcnt_q) && $stable(wadr_q))); // R6
  AST_COMPLETE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> wcnt_q == '0); // R11

endmodule

// File: rtl/dmac_stat.sv
module dmac_stat
  import dmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              set_done,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [3:1]        wclr,
  input  logic              w1c_mode,
  input  logic              core_irq,
  output logic [DATA_W-1:0] stat_view
);

  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] clr;
  logic [ST_W-1:0] st_d;

  always_comb begin
    clr = '0;
    if (wr_stat && w1c_mode)  clr[3:1] = wclr;
    if (rd_stat && !w1c_mode) clr[3:1] = 3'b111;
    if (start_p)              clr = '1;
    st_d = st_q & ~clr;
    st_d[ST_IRQ] = 1'b0;
    if (set_done) st_d[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_comb begin
    stat_view = '0;
    stat_view[ST_W-1:0] = st_q;
    stat_view[ST_IRQ] = core_irq;
  end

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> st_q[ST_DONE]); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !w1c_mode && !set_done) |=> st_q[3:1] == 3'b000); // R9
  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !w1c_mode && !rd_stat && !set_done && !start_p) |=> $stable(st_q)); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && w1c_mode && wclr[ST_DONE] && !set_done) |=> !st_q[ST_DONE]); // R8

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmac_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stat_w1c_mode,
  input  logic              core_irq,
  input  logic              core_cmd_done,
  output logic              dma_en,
  output logic              core_cancel,
  input  logic              chunk_valid,
  output logic              chunk_ready,
  input  logic              chunk_to_mem,
  input  logic [DATA_W-1:0] chunk_len,
  output logic [DATA_W-1:0] chunk_grant
);

  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdsc_q, wcnt_q, wadr_q, wdsc_q, stat_view;
  logic              start_p, set_done;
  logic              wr_cmd, wr_scnt, wr_sadr, wr_sdsc, wr_stat, rd_stat;

  assign wr_cmd  = reg_wr && (reg_idx == IX_CMD);
  assign wr_scnt = reg_wr && (reg_idx == IX_SCNT);
  assign wr_sadr = reg_wr && (reg_idx == IX_SADR);
  assign wr_sdsc = reg_wr && (reg_idx == IX_SDSC);
  assign wr_stat = reg_wr && (reg_idx == IX_STAT);
  assign rd_stat = reg_rd && (reg_idx == IX_STAT);

  assign chunk_ready = !reg_wr;

  dmac_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .wdata(reg_wdata),
    .cmd_q(cmd_q), .start_p(start_p), .dma_en(dma_en), .cancel(core_cancel)
  );

  dmac_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .wr_scnt(wr_scnt), .wr_sadr(wr_sadr), .wr_sdsc(wr_sdsc), .wdata(reg_wdata),
    .start_p(start_p), .cmd_dir(cmd_q[CMD_DIR_BIT]), .done_evt(core_cmd_done),
    .chk_valid(chunk_valid), .chk_ready(chunk_ready), .chk_to_mem(chunk_to_mem),
    .chk_len(chunk_len),
    .scnt_q(scnt_q), .sadr_q(sadr_q), .sdsc_q(sdsc_q),
    .wcnt_q(wcnt_q), .wadr_q(wadr_q), .wdsc_q(wdsc_q),
    .grant(chunk_grant), .set_done(set_done)
  );

  dmac_stat #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .set_done(set_done),
    .wr_stat(wr_stat), .rd_stat(rd_stat), .wclr(reg_wdata[3:1]),
    .w1c_mode(stat_w1c_mode), .core_irq(core_irq), .stat_view(stat_view)
  );

  always_comb begin
    unique case (reg_idx_e'(reg_idx))
      IX_CMD:  reg_rdata = cmd_q;
      IX_SCNT: reg_rdata = scnt_q;
      IX_SADR: reg_rdata = sadr_q;
      IX_WCNT: reg_rdata = wcnt_q;
      IX_WADR: reg_rdata = wadr_q;
      IX_STAT: reg_rdata = stat_view;
      IX_SDSC: reg_rdata = sdsc_q;
      default: reg_rdata = wdsc_q;
    endcase
  end

  AST_START_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !core_cmd_done) |=> wcnt_q == $past(scnt_q)); // R3
  AST_BLOCKED_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !start_p && !core_cmd_done) |=> $stable(wcnt_q)); // R5
  AST_WDSC_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_p |=> $stable(wdsc_q)); // R2

endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        stat_w1c_mode = 1'b1, core_irq = 1'b0, core_cmd_done = 1'b0;
  logic        dma_en, core_cancel;
  logic        chunk_valid = 1'b0, chunk_ready, chunk_to_mem = 1'b0;
  logic [31:0] chunk_len = '0, chunk_grant;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_w1c_mode(stat_w1c_mode),
    .core_irq(core_irq), .core_cmd_done(core_cmd_done), .dma_en(dma_en),
    .core_cancel(core_cancel), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_to_mem(chunk_to_mem), .chunk_len(chunk_len), .chunk_grant(chunk_grant)
  );

  int n_chk = 0, n_bad = 0;

  logic [31:0] m_cmd = 0, m_scnt = 0, m_sadr = 0, m_sdsc = 0;
  logic [31:0] m_wcnt = 0, m_wadr = 32'hFFFF_FFFF, m_wdsc = 32'hFFFF_FFFD;
  logic [5:0]  m_st = 0;
  logic        m_en = 0, m_cancel = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [2:0] idx);
    case (idx)
      3'd0: return m_cmd;
      3'd1: return m_scnt;
      3'd2: return m_sadr;
      3'd3: return m_wcnt;
      3'd4: return m_wadr;
      3'd5: return {26'd0, m_st[5], core_irq, m_st[3:0]};
      3'd6: return m_sdsc;
      default: return m_wdsc;
    endcase
  endfunction

  function automatic logic [31:0] clamp_of(input logic [31:0] len, input logic [31:0] cnt);
    return (len < cnt) ? len : cnt;
  endfunction

  task automatic do_write(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
    #1 check("R5 ready low on write", {31'd0, chunk_ready}, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    m_cancel = 1'b0;
    case (idx)
      3'd0: begin
        m_cmd = data;
        case (data[1:0])
          2'd0: m_en = 1'b0;
          2'd2: m_cancel = 1'b1;
          2'd3: begin
            m_wcnt = m_scnt; m_wadr = m_sadr; m_wdsc = m_sdsc; m_st = '0; m_en = 1'b1;
          end
          default: ;
        endcase
      end
      3'd1: m_scnt = data;
      3'd2: m_sadr = data;
      3'd6: m_sdsc = data;
      3'd5: if (stat_w1c_mode) m_st = m_st & ~{2'b00, data[3:1], 1'b0};
      default: ;
    endcase
    #1;
    check("R3/R4 dma_en", {31'd0, dma_en}, {31'd0, m_en});
    check("R4 cancel", {31'd0, core_cancel}, {31'd0, m_cancel});
  endtask

  task automatic do_read(input logic [2:0] idx, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_idx = idx;
    #1 check(req, reg_rdata, model_read(idx));
    @(negedge clk);
    reg_rd = 1'b0;
    if (idx == 3'd5 && !stat_w1c_mode) m_st[3:1] = 3'b000;
    #1 check("R4 cancel idle", {31'd0, core_cancel}, 32'd0);
  endtask

  task automatic do_chunk(input logic dir, input logic [31:0] len, input string req);
    logic        ok;
    logic [31:0] g;
    @(negedge clk);
    chunk_valid = 1'b1; chunk_to_mem = dir; chunk_len = len;
    ok = (dir == m_cmd[7]);
    g  = ok ? clamp_of(len, m_wcnt) : 32'd0;
    #1;
    check({req, " grant"}, chunk_grant, g);
    check("R5 ready", {31'd0, chunk_ready}, 32'd1);
    @(negedge clk);
    chunk_valid = 1'b0;
    if (ok) begin
      if (g == m_wcnt) m_st[3] = 1'b1;
      m_wcnt = m_wcnt - g;
      m_wadr = m_wadr + g;
    end
  endtask

  task automatic do_complete();
    @(negedge clk);
    core_cmd_done = 1'b1;
    @(negedge clk);
    core_cmd_done = 1'b0;
    m_wcnt = 0; m_st[3] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 dma_en", {31'd0, dma_en}, 32'd0);
    check("R1 cancel", {31'd0, core_cancel}, 32'd0);
    for (int i = 0; i < 8; i++) do_read(3'(i), "R1 reset value");

    // R2 store and ignore
    do_write(3'd1, 32'hA5A5_0F0F);
    do_write(3'd2, 32'h1234_5678);
    do_write(3'd6, 32'hDEAD_BEE0);
    do_write(3'd3, 32'h0000_1111);
    do_write(3'd4, 32'h0000_2222);
    do_write(3'd7, 32'h0000_3333);
    for (int i = 1; i < 8; i++) do_read(3'(i), "R2 readback");

    // R3 start, direction to memory
    do_write(3'd1, 32'd100);
    do_write(3'd0, 32'h0000_0083);
    do_read(3'd3, "R3 wcnt loaded");
    do_read(3'd4, "R3 wadr loaded");
    do_read(3'd7, "R3 wdsc loaded");

    // R5 back-pressure: chunk during a write is not taken
    @(negedge clk);
    chunk_valid = 1'b1; chunk_to_mem = 1'b1; chunk_len = 32'd10;
    reg_wr = 1'b1; reg_idx = 3'd3; reg_wdata = 32'd0;
    #1 check("R5 ready low", {31'd0, chunk_ready}, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0; chunk_valid = 1'b0;
    do_read(3'd3, "R5 count held under back-pressure");

    // R6 mismatched direction
    do_chunk(1'b0, 32'd30, "R6 mismatch");
    do_read(3'd3, "R6 count unchanged");
    do_read(3'd4, "R6 address unchanged");

    // R5 / R7 chunks to zero with clamp
    stat_w1c_mode = 1'b1;
    do_chunk(1'b1, 32'd60, "R5 partial");
    do_read(3'd5, "R7 not done yet");
    do_chunk(1'b1, 32'd60, "R5 clamped");
    do_read(3'd3, "R7 count zero");
    do_read(3'd4, "R5 address advanced");
    do_read(3'd5, "R7 done set");

    // R8 write-one-to-clear
    do_read(3'd5, "R8 read does not clear");
    do_write(3'd5, 32'h0000_0004);
    do_read(3'd5, "R8 other bit kept");
    do_write(3'd5, 32'h0000_0008);
    do_read(3'd5, "R8 done cleared");

    // R11 completion, then R9 clear-on-read
    do_complete();
    stat_w1c_mode = 1'b0;
    do_read(3'd3, "R11 count forced zero");
    do_write(3'd5, 32'h0000_000E);
    do_read(3'd5, "R9 write ignored, done visible");
    do_read(3'd5, "R9 cleared by read");

    // R10 live interrupt
    core_irq = 1'b1;
    do_read(3'd5, "R10 irq visible");
    core_irq = 1'b0;
    do_read(3'd5, "R10 irq not held");

    // R4 commands
    do_write(3'd0, 32'h0000_0001);
    do_write(3'd0, 32'h0000_0002);
    do_write(3'd0, 32'h0000_0000);
    do_write(3'd0, 32'h0000_0002);

    // mixed random traffic
    for (int it = 0; it < 2500; it++) begin
      int unsigned sel;
      logic [2:0]  ix;
      logic [31:0] d;
      if (it % 250 == 0) stat_w1c_mode = 1'($urandom_range(0, 1));
      core_irq = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 99);
      ix  = 3'($urandom_range(0, 7));
      if (sel < 20) begin
        d = $urandom();
        if (ix == 3'd1 || $urandom_range(0, 1) == 0) d = $urandom_range(0, 200);
        do_write(ix, d);
      end else if (sel < 28) begin
        d = $urandom();
        d[1:0] = 2'($urandom_range(0, 3));
        do_write(3'd0, d);
      end else if (sel < 55) begin
        do_read(ix, "R2/R9 random read");
      end else if (sel < 95) begin
        do_chunk(1'($urandom_range(0, 1)), $urandom_range(0, 80), "R5/R6 random");
      end else begin
        do_complete();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule